// File: doc/BRIEF.md
# AUX Channel Byte Tap with Microsecond Timestamps

The tap watches the byte traffic that a local controller exchanges over a bidirectional, byte-oriented sideband channel. It turns each byte into one beat on a valid-qualified stream, so the stream can go straight into a capture FIFO for later inspection. Bytes arrive on two event ports, one for transmitted bytes and one for received bytes. Each event port has a byte, a strobe, start and end markers and an error flag.

Each beat is `TS_W + 8` bits wide. The upper field holds a free-running microsecond count, made by dividing the channel clock by `CLK_PER_US`. The low byte holds the captured byte. Side flags mark the start of a message, the closing beat, a byte error and the direction of travel. After the last byte of a message, the tap emits one extra closing beat that carries no message byte. Consumers discard that beat's data.

The output has no backpressure, and at most one beat leaves per clock. When both sides strobe in the same cycle, the transmitted byte goes out first. The received byte waits in a one-entry holding slot and leaves on the following cycle.

Top module: `aux_byte_tap`

## Requirements
- R1: A strobed byte produces one beat whose bits [7:0] equal the byte. A transmit strobe is visible on the output in the cycle after the strobing edge. A receive strobe with no competing beat is also visible in that cycle.
- R2: Bits [TS_W+7:8] of every beat hold the timestamp counter value at the edge that registers the beat. The counter is 0 after reset and increments once every `CLK_PER_US` clocks. It wraps modulo 2^TS_W.
- R3: The direction flag is 1 for beats that come from the transmit port and 0 for beats that come from the receive port. A closing beat carries the direction of the message it ends.
- R4: The start flag is 1 on a byte strobed together with its start marker. It is also 1 on any byte that arrives while no message on that side is open, which is the case after reset or after a byte with the end marker.
- R5: A byte strobed with its end marker is followed by a separate closing beat. That beat has end flag 1, data byte 0, start flag 0 and error flag 0. Byte beats always have end flag 0.
- R6: The error flag of a byte beat equals the error input sampled with that byte.
- R7: Valid is high for exactly one clock per beat. Start, end and error inputs presented without a strobe produce no beat and do not change the message state.
- R8: When both ports strobe in the same cycle, the transmit beat is output first. The receive beat is output on the next cycle.
- R9: Each cycle selects the output beat in this priority order: transmit byte, held receive byte, live receive byte, transmit closing beat, receive closing beat.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_stb_i | input | 1 | Transmitted byte strobe |
| tx_data_i | input | 8 | Transmitted byte |
| tx_start_i | input | 1 | Transmitted byte opens a message |
| tx_end_i | input | 1 | Transmitted byte closes a message |
| tx_err_i | input | 1 | Error on transmitted byte |
| rx_stb_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_start_i | input | 1 | Received byte opens a message |
| rx_end_i | input | 1 | Received byte closes a message |
| rx_err_i | input | 1 | Error on received byte |
| beat_data_o | output | TS_W+8 | Timestamp in upper bits, byte in [7:0] |
| beat_valid_o | output | 1 | Beat qualifier |
| beat_sop_o | output | 1 | First byte of a message |
| beat_eop_o | output | 1 | Closing beat, data to be ignored |
| beat_err_o | output | 1 | Byte error |
| beat_dir_o | output | 1 | 1 transmitted, 0 received |

## Verification
The properties assume that strobes on each port are at least four cycles apart. Channel bytes on a real link are far sparser than that, and this spacing lets the holding slot and both closing beats drain before the next byte on either side arrives. The properties also assume that a byte with an end marker is never followed by a further byte on the same side before that side's closing beat has left. The random stimulus enforces both conditions with a per-port gap counter that allows a new strobe only after three idle cycles. Every directed sequence leaves the same spacing.

// File: rtl/aux_tap_pkg.sv
package aux_tap_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              err;
    logic              last;
  } tap_evt_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TX_BYTE,
    SEL_RX_HELD,
    SEL_RX_BYTE,
    SEL_TX_TERM,
    SEL_RX_TERM
  } tap_sel_e;
endpackage

// File: rtl/aux_tap_timebase.sv
module aux_tap_timebase #(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned TS_W       = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  localparam int unsigned DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ts_o  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) ts_o <= ts_o + 1'b1;  // wraps modulo 2^TS_W
    end
  end
endmodule

// File: rtl/aux_tap_framer.sv
module aux_tap_framer
  import aux_tap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              err_i,
  output tap_evt_t          evt_o,
  output logic              evt_vld_o
);
  logic in_pkt_q;

  always_comb begin
    evt_vld_o  = stb_i;
    evt_o.data = data_i;
    evt_o.sop  = start_i | ~in_pkt_q;  // orphan byte opens a message
    evt_o.err  = err_i;
    evt_o.last = end_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    in_pkt_q <= 1'b0;
    else if (stb_i) in_pkt_q <= ~end_i;
  end
endmodule

// File: rtl/aux_tap_sched.sv
module aux_tap_sched
  import aux_tap_pkg::*;
#(
  parameter int unsigned TS_W = 24,
  localparam int unsigned BEAT_W = TS_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tap_evt_t          tx_evt_i,
  input  logic              tx_vld_i,
  input  tap_evt_t          rx_evt_i,
  input  logic              rx_vld_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic [BEAT_W-1:0] beat_data_o,
  output logic              beat_valid_o,
  output logic              beat_sop_o,
  output logic              beat_eop_o,
  output logic              beat_err_o,
  output logic              beat_dir_o
);
  tap_sel_e sel;
  tap_evt_t held_q, held_d;
  logic     held_vld_q, held_vld_d;
  logic     tx_term_q, tx_term_d;
  logic     rx_term_q, rx_term_d;
  tap_evt_t pick;
  logic     pick_dir, pick_eop;

  always_comb begin
    if (tx_vld_i)        sel = SEL_TX_BYTE;
    else if (held_vld_q) sel = SEL_RX_HELD;
    else if (rx_vld_i)   sel = SEL_RX_BYTE;
    else if (tx_term_q)  sel = SEL_TX_TERM;
    else if (rx_term_q)  sel = SEL_RX_TERM;
    else                 sel = SEL_NONE;
  end

  always_comb begin
    pick     = '0;
    pick_dir = 1'b0;
    pick_eop = 1'b0;
    unique case (sel)
      SEL_TX_BYTE: begin pick = tx_evt_i; pick_dir = 1'b1; end
      SEL_RX_HELD: pick = held_q;
      SEL_RX_BYTE: pick = rx_evt_i;
      SEL_TX_TERM: begin pick_dir = 1'b1; pick_eop = 1'b1; end
      SEL_RX_TERM: pick_eop = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    held_vld_d = (held_vld_q && sel != SEL_RX_HELD) || (rx_vld_i && sel != SEL_RX_BYTE);
    held_d     = (rx_vld_i && sel != SEL_RX_BYTE) ? rx_evt_i : held_q;
    tx_term_d  = (tx_term_q && sel != SEL_TX_TERM) || (sel == SEL_TX_BYTE && tx_evt_i.last);
    rx_term_d  = (rx_term_q && sel != SEL_RX_TERM)
              || (sel == SEL_RX_HELD && held_q.last)
              || (sel == SEL_RX_BYTE && rx_evt_i.last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q       <= '0;
      held_vld_q   <= 1'b0;
      tx_term_q    <= 1'b0;
      rx_term_q    <= 1'b0;
      beat_data_o  <= '0;
      beat_valid_o <= 1'b0;
      beat_sop_o   <= 1'b0;
      beat_eop_o   <= 1'b0;
      beat_err_o   <= 1'b0;
      beat_dir_o   <= 1'b0;
    end else begin
      held_q       <= held_d;
      held_vld_q   <= held_vld_d;
      tx_term_q    <= tx_term_d;
      rx_term_q    <= rx_term_d;
      beat_valid_o <= (sel != SEL_NONE);
      beat_data_o  <= {ts_i, pick.data};
      beat_sop_o   <= pick.sop;
      beat_eop_o   <= pick_eop;
      beat_err_o   <= pick.err;
      beat_dir_o   <= pick_dir;
    end
  end
endmodule

// File: rtl/aux_byte_tap.sv
module aux_byte_tap
  import aux_tap_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned TS_W       = 24,
  localparam int unsigned BEAT_W    = TS_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_stb_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_start_i,
  input  logic              tx_end_i,
  input  logic              tx_err_i,
  input  logic              rx_stb_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_start_i,
  input  logic              rx_end_i,
  input  logic              rx_err_i,
  output logic [BEAT_W-1:0] beat_data_o,
  output logic              beat_valid_o,
  output logic              beat_sop_o,
  output logic              beat_eop_o,
  output logic              beat_err_o,
  output logic              beat_dir_o
);
  localparam int unsigned N_SIDE = 2;  // index = direction flag

  logic [TS_W-1:0]   ts_q;
  logic [N_SIDE-1:0] side_stb, side_start, side_end, side_err, evt_vld;
  logic [BYTE_W-1:0] side_data [N_SIDE];
  tap_evt_t          evt [N_SIDE];

  assign side_stb   = {tx_stb_i,   rx_stb_i};
  assign side_start = {tx_start_i, rx_start_i};
  assign side_end   = {tx_end_i,   rx_end_i};
  assign side_err   = {tx_err_i,   rx_err_i};
  assign side_data[0] = rx_data_i;
  assign side_data[1] = tx_data_i;

  aux_tap_timebase #(.CLK_PER_US(CLK_PER_US), .TS_W(TS_W)) i_timebase (
    .clk_i, .rst_ni, .ts_o(ts_q)
  );

  for (genvar gi = 0; gi < N_SIDE; gi++) begin : g_side
    aux_tap_framer i_framer (
      .clk_i, .rst_ni,
      .stb_i    (side_stb[gi]),
      .data_i   (side_data[gi]),
      .start_i  (side_start[gi]),
      .end_i    (side_end[gi]),
      .err_i    (side_err[gi]),
      .evt_o    (evt[gi]),
      .evt_vld_o(evt_vld[gi])
    );
  end

  aux_tap_sched #(.TS_W(TS_W)) i_sched (
    .clk_i, .rst_ni,
    .tx_evt_i    (evt[1]),
    .tx_vld_i    (evt_vld[1]),
    .rx_evt_i    (evt[0]),
    .rx_vld_i    (evt_vld[0]),
    .ts_i        (ts_q),
    .beat_data_o, .beat_valid_o, .beat_sop_o, .beat_eop_o, .beat_err_o, .beat_dir_o
  );
endmodule

// File: rtl/aux_byte_tap_chk.sv
module aux_byte_tap_chk #(
  parameter int unsigned TS_W = 24
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_stb_i,
  input logic [7:0]      tx_data_i,
  input logic            tx_start_i,
  input logic            tx_err_i,
  input logic            rx_stb_i,
  input logic [TS_W-1:0] ts_i,
  input logic [TS_W+7:0] beat_data_o,
  input logic            beat_valid_o,
  input logic            beat_sop_o,
  input logic            beat_eop_o,
  input logic            beat_err_o,
  input logic            beat_dir_o
);
  // R1
  tx_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_i |=> beat_valid_o && beat_dir_o && !beat_eop_o
                 && beat_data_o[7:0] == $past(tx_data_i)
                 && beat_data_o[TS_W+7:8] == $past(ts_i));

  // R2
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ts_i) |-> ts_i == TS_W'($past(ts_i) + 1'b1));

  // R4
  tx_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stb_i && tx_start_i) |=> beat_sop_o);

  // R5
  term_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_eop_o) |-> beat_data_o[7:0] == 8'h00 && !beat_err_o && !beat_sop_o);

  // R6
  tx_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_i |=> beat_err_o == $past(tx_err_i));

  // R8
  coincide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stb_i && rx_stb_i) |=> (beat_valid_o && beat_dir_o)
                               ##1 (beat_valid_o && !beat_dir_o && !beat_eop_o));
endmodule

bind aux_byte_tap aux_byte_tap_chk #(.TS_W(TS_W)) i_chk (
  .clk_i, .rst_ni, .tx_stb_i, .tx_data_i, .tx_start_i, .tx_err_i, .rx_stb_i,
  .ts_i(ts_q), .beat_data_o, .beat_valid_o, .beat_sop_o, .beat_eop_o,
  .beat_err_o, .beat_dir_o
);

// File: tb/test_aux_byte_tap.sv
`timescale 1ns/1ps
module test_aux_byte_tap;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic       tx_stb = 0, tx_start = 0, tx_end = 0, tx_err = 0;
  logic       rx_stb = 0, rx_start = 0, rx_end = 0, rx_err = 0;
  logic [7:0] tx_data = 0, rx_data = 0;

  logic [31:0] beat_data;
  logic        beat_valid, beat_sop, beat_eop, beat_err, beat_dir;
  logic [11:0] w_data;
  logic        w_valid, w_sop, w_eop, w_err, w_dir;

  aux_byte_tap i_aux_byte_tap (
    .clk_i, .rst_ni,
    .tx_stb_i(tx_stb), .tx_data_i(tx_data), .tx_start_i(tx_start), .tx_end_i(tx_end), .tx_err_i(tx_err),
    .rx_stb_i(rx_stb), .rx_data_i(rx_data), .rx_start_i(rx_start), .rx_end_i(rx_end), .rx_err_i(rx_err),
    .beat_data_o(beat_data), .beat_valid_o(beat_valid), .beat_sop_o(beat_sop),
    .beat_eop_o(beat_eop), .beat_err_o(beat_err), .beat_dir_o(beat_dir)
  );

  // small timestamp so that wrap-around is reached quickly (R2)
  aux_byte_tap #(.CLK_PER_US(2), .TS_W(4)) i_aux_byte_tap_wrap (
    .clk_i, .rst_ni,
    .tx_stb_i(tx_stb), .tx_data_i(tx_data), .tx_start_i(tx_start), .tx_end_i(tx_end), .tx_err_i(tx_err),
    .rx_stb_i(rx_stb), .rx_data_i(rx_data), .rx_start_i(rx_start), .rx_end_i(rx_end), .rx_err_i(rx_err),
    .beat_data_o(w_data), .beat_valid_o(w_valid), .beat_sop_o(w_sop),
    .beat_eop_o(w_eop), .beat_err_o(w_err), .beat_dir_o(w_dir)
  );

  int unsigned n_chk = 0, n_fail = 0, edges = 0;
  bit done = 0;
  always @(posedge clk_i) if (rst_ni) edges <= edges + 1;

  // reference model state
  bit         m_in_tx, m_in_rx, m_hv, m_hsop, m_herr, m_hlast, m_tt, m_rt;
  logic [7:0] m_hdata;
  bit         e_valid, e_sop, e_eop, e_err, e_dir;
  logic [7:0] e_byte;
  logic [23:0] e_ts;
  logic [3:0]  e_wts;
  int          e_src;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R7 valid", 32'(beat_valid), 32'(e_valid));
    chk("R7 valid_wrap", 32'(w_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R1 byte", 32'(beat_data[7:0]), 32'(e_byte));
      chk("R2 ts", 32'(beat_data[31:8]), 32'(e_ts));
      chk("R2 ts_wrap", 32'(w_data[11:8]), 32'(e_wts));
      chk(e_src == 2 ? "R8 dir" : (e_src >= 4 ? "R9 dir" : "R3 dir"), 32'(beat_dir), 32'(e_dir));
      chk("R4 sop", 32'(beat_sop), 32'(e_sop));
      chk("R5 eop", 32'(beat_eop), 32'(e_eop));
      chk("R6 err", 32'(beat_err), 32'(e_err));
    end
  endtask

  task automatic model();
    bit t_sop, r_sop, nhv, ntt, nrt;
    int sel;
    t_sop = tx_start | !m_in_tx;
    r_sop = rx_start | !m_in_rx;
    if (tx_stb) m_in_tx = !tx_end;
    if (rx_stb) m_in_rx = !rx_end;
    if (tx_stb)    sel = 1;
    else if (m_hv) sel = 2;
    else if (rx_stb) sel = 3;
    else if (m_tt) sel = 4;
    else if (m_rt) sel = 5;
    else sel = 0;
    e_valid = (sel != 0);
    e_src = sel;
    e_ts  = 24'(edges / 16);
    e_wts = 4'(edges / 2);
    e_byte = 0; e_sop = 0; e_eop = 0; e_err = 0; e_dir = 0;
    case (sel)
      1: begin e_byte = tx_data; e_sop = t_sop; e_err = tx_err; e_dir = 1; end
      2: begin e_byte = m_hdata; e_sop = m_hsop; e_err = m_herr; end
      3: begin e_byte = rx_data; e_sop = r_sop; e_err = rx_err; end
      4: begin e_eop = 1; e_dir = 1; end
      5: e_eop = 1;
      default: ;
    endcase
    nhv = (m_hv && sel != 2) || (rx_stb && sel != 3);
    ntt = (m_tt && sel != 4) || (sel == 1 && tx_end);
    nrt = (m_rt && sel != 5) || (sel == 2 && m_hlast) || (sel == 3 && rx_end);
    if (rx_stb && sel != 3) begin
      m_hdata = rx_data; m_hsop = r_sop; m_herr = rx_err; m_hlast = rx_end;
    end
    m_hv = nhv; m_tt = ntt; m_rt = nrt;
  endtask

  task automatic step(bit ts_, bit tst, bit te, bit ter, logic [7:0] tb,
                      bit rs, bit rst_, bit re, bit rer, logic [7:0] rb);
    @(negedge clk_i);
    compare();
    tx_stb = ts_; tx_start = tst; tx_end = te; tx_err = ter; tx_data = tb;
    rx_stb = rs;  rx_start = rst_; rx_end = re; rx_err = rer; rx_data = rb;
    model();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,8'h00, 0,0,0,0,8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int gap_tx, gap_rx;
    void'($urandom(32'h5eed_a0c1));
    e_valid = 0; e_src = 0;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10 valid", 32'(beat_valid), 0);
    chk("R10 data", beat_data, 0);
    chk("R10 flags", {28'd0, beat_sop, beat_eop, beat_err, beat_dir}, 0);
    rst_ni = 1'b1;

    // R1 R4 R5: three-byte transmit message
    step(1,1,0,0,8'hA1, 0,0,0,0,0); idle(3);
    step(1,0,0,1,8'hA2, 0,0,0,0,0); idle(3);   // R6 error byte
    step(1,0,1,0,8'hA3, 0,0,0,0,0); idle(4);
    // R4: orphan receive byte, no start marker, also closes
    step(0,0,0,0,0, 1,0,1,0,8'h5C); idle(4);
    // R7: markers without strobe are ignored
    for (int i = 0; i < 4; i++) step(0,1,1,1,8'hFF, 0,1,1,1,8'hEE);
    idle(2);
    // R8 R9: coincident single-byte messages on both sides
    step(1,1,1,0,8'h11, 1,1,1,1,8'h22); idle(5);
    // R8: coincident, receive side stays open then closes
    step(1,1,0,0,8'h33, 1,1,0,0,8'h44); idle(3);
    step(1,0,1,0,8'h35, 1,0,1,0,8'h46); idle(5);

    // constrained random traffic: strobes at least four cycles apart per side
    gap_tx = 10; gap_rx = 10;
    for (int c = 0; c < 6000; c++) begin
      bit ts_, rs;
      ts_ = (gap_tx >= 4) && ($urandom % 3 == 0);
      rs  = (gap_rx >= 4) && ($urandom % 3 == 0);
      gap_tx = ts_ ? 1 : gap_tx + 1;
      gap_rx = rs  ? 1 : gap_rx + 1;
      step(ts_, ($urandom % 4 == 0), ($urandom % 4 == 0), ($urandom % 8 == 0), 8'($urandom),
           rs,  ($urandom % 4 == 0), ($urandom % 4 == 0), ($urandom % 8 == 0), 8'($urandom));
    end
    idle(8);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule